// File: doc/BRIEF.md
# Keyed Data EEPROM Access Controller

This block fronts a small byte-wide nonvolatile data store with four bus-visible registers: an address register, a data register, a control register and a write-only key register. Software reads a byte by loading the address and then setting the read bit in the control register. The byte lands in the data register on the following clock edge. It stays there until another read completes or until software writes the data register directly.

Programming a byte is guarded. Software must first set the write-enable bit. It then writes the two key bytes (55h, then AAh) on consecutive bus writes, and on the bus write right after those it sets the write bit. Only then does a write cycle start. The cycle latches the address and data, keeps the write bit at 1 for a fixed number of clock cycles, and then stores the byte. At that point it clears the write bit and raises a sticky completion flag that only software can clear. An interrupt output follows the flag, gated by an enable input.

The store is an internal array written to suit block-RAM inference. The write latency is set by a parameter.

Top module: `eekey_ctl`

## Requirements
- R1: A synchronous active-high reset clears the control register to 00h, the completion flag and the key tracker. It leaves the stored bytes unchanged.
- R2: Register selects are 0 address, 1 data, 2 control and 3 key. Control bits are: 0 read (always reads 0), 1 write/busy, 2 write enable, 4 completion flag, and 7:6 memory select. A control write with bit 0 set and bits 7:6 equal to 00, made while no write is in progress, loads the byte at the current address into the data register by the next clock edge. With bits 7:6 nonzero, no read happens.
- R3: A write starts only if three bus writes come back to back: key 55h, key AAh, then a control write with bit 1 set. A wrong key value, the two keys in the wrong order, or any other bus write between them prevents the write.
- R4: Each control write made after the two keys consumes the unlock, whether or not it starts a write. Every further byte needs both keys again.
- R5: The write enable bit must already hold 1 from an earlier bus write. A control write that sets bits 1 and 2 together starts no write. A write is also refused when bits 7:6 are nonzero.
- R6: Once a write starts, bit 1 reads 1 for exactly WR_CYCLES clock cycles. The byte stored is the address and data held at the start. Clearing write enable, or changing the address or data register, during the write does not alter it.
- R7: When the write cycle ends, bit 1 returns to 0, the completion flag (bit 4) becomes 1, and the new byte can be read back.
- R8: The completion flag is cleared only by a control write with bit 4 equal to 0. A control write with bit 4 equal to 1 never sets it.
- R9: While a write is in progress, read requests and new write requests are ignored.
- R10: The irq output is high exactly when the completion flag and the irq_en input are both high.
- R11: The data register keeps its value across writes to other registers and idle cycles. It changes only on a completed read or a direct write to the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one bus write per cycle |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| addr_q | output | AW | Address register |
| data_q | output | 8 | Data register |
| ctrl_q | output | 8 | Control register as software reads it |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume the bus makes at most one register write per cycle. They also assume reset is asserted from the first cycle, so the key tracker and write timer start from a known state. The stimulus drives every bus write as a single-cycle strobe that changes only between clock edges, and it holds reset from time zero. The checks on unlock order rely on the strobe being low on every cycle that is not meant as a bus write, and the bench never raises it otherwise.

// File: rtl/eekey_pkg.sv
package eekey_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_st_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int B_READ = 0;
  localparam int B_WR   = 1;
  localparam int B_WREN = 2;
  localparam int B_FLAG = 4;
  localparam int B_MSLO = 6;
  localparam int B_MSHI = 7;
endpackage

// File: rtl/eekey_tracker.sv
module eekey_tracker
  import eekey_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       armed
);
  key_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KEY_IDLE;
    end else if (bus_wr) begin
      if (bus_sel == SEL_KEY && bus_wdata == KEY_FIRST && st_q == KEY_IDLE)
        st_q <= KEY_HALF;
      else if (bus_sel == SEL_KEY && bus_wdata == KEY_SECOND && st_q == KEY_HALF)
        st_q <= KEY_ARMED;
      else
        st_q <= KEY_IDLE;
    end
  end

  assign armed = (st_q == KEY_ARMED);

  // R3: being armed means the previous bus write was the second key byte
  assert_armed_after_key_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> $past(bus_wr && bus_sel == SEL_KEY && bus_wdata == KEY_SECOND));

  // R4: any control write consumes the unlock
  assert_unlock_consumed_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == SEL_CTRL) |=> !armed);
endmodule

// File: rtl/eekey_timer.sv
module eekey_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(WR_CYCLES - 1);
    end
  end

  assign done = busy && (cnt_q == '0);

  // R6: a started write shows busy on the next cycle
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R6: busy does not drop before the end of the cycle
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/eekey_store.sv
module eekey_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          sw_load,
  input  logic [7:0]    sw_data,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    dat_q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          dat_q <= 8'h00;
    else if (rd_go)   dat_q <= mem[rd_addr];
    else if (sw_load) dat_q <= sw_data;
  end
endmodule

// File: rtl/eekey_ctl.sv
module eekey_ctl
  import eekey_pkg::*;
#(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [7:0]    bus_wdata,
  input  logic          irq_en,
  output logic [AW-1:0] addr_q,
  output logic [7:0]    data_q,
  output logic [7:0]    ctrl_q,
  output logic          irq
);
  logic          armed, busy, done;
  logic          ctrl_wr, rd_go, wr_start;
  logic [1:0]    ms_r;
  logic          wren_r, flag_r;
  logic [AW-1:0] wa_r;
  logic [7:0]    wd_r;

  assign ctrl_wr  = bus_wr && (bus_sel == SEL_CTRL);
  assign rd_go    = ctrl_wr && bus_wdata[B_READ] &&
                    (bus_wdata[B_MSHI:B_MSLO] == 2'b00) && !busy;
  assign wr_start = ctrl_wr && armed && wren_r && bus_wdata[B_WR] &&
                    (bus_wdata[B_MSHI:B_MSLO] == 2'b00) && !busy;

  eekey_tracker i_tracker (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .armed(armed)
  );

  eekey_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .start(wr_start), .busy(busy), .done(done)
  );

  eekey_store #(.AW(AW)) i_store (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .rd_addr(addr_q),
    .sw_load(bus_wr && bus_sel == SEL_DATA), .sw_data(bus_wdata),
    .wr_go(done), .wr_addr(wa_r), .wr_data(wd_r),
    .dat_q(data_q)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (bus_wr && bus_sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_start) begin
      wa_r <= addr_q;
      wd_r <= data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_r   <= 2'b00;
      wren_r <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ms_r   <= bus_wdata[B_MSHI:B_MSLO];
        wren_r <= bus_wdata[B_WREN];
        if (!bus_wdata[B_FLAG]) flag_r <= 1'b0;
      end
      if (done) flag_r <= 1'b1;
    end
  end

  assign ctrl_q = {ms_r, 1'b0, flag_r, 1'b0, wren_r, busy, 1'b0};
  assign irq    = flag_r & irq_en;

  // R3: a write cycle begins only right after the key pair
  assert_key_before_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  // R5: write enable was held before the starting bus write
  assert_wren_prior_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wren_r));

  // R7: end of cycle clears busy and raises the flag
  assert_done_flag_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (flag_r && !busy));

  // R8: flag survives unless software writes a zero to it
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_r && !(ctrl_wr && !bus_wdata[B_FLAG])) |=> flag_r);

  // R8: flag rises only at write completion
  assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_r) |-> $past(done));
endmodule

// File: tb/test_eekey_ctl.sv
module test_eekey_ctl;
  localparam int AW  = 8;
  localparam int WRC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_sel = 2'd0;
  logic [7:0]    bus_wdata = 8'h00;
  logic          irq_en = 1'b0;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, ctrl_q;
  logic          irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  eekey_ctl #(.AW(AW), .WR_CYCLES(WRC)) i_eekey_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .irq_en(irq_en), .addr_q(addr_q),
    .data_q(data_q), .ctrl_q(ctrl_q), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] sel, input logic [7:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic unlock();
    bw(2'd3, 8'h55);
    bw(2'd3, 8'hAA);
  endtask

  task automatic count_busy(output int c);
    c = 0;
    while (ctrl_q[1] && c < 1000) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic rd_byte(input logic [7:0] a);
    bw(2'd0, a);
    bw(2'd2, 8'h05);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ctrl after reset", ctrl_q, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_write_basic();
    int c;
    bw(2'd2, 8'h04);
    bw(2'd0, 8'h05);
    bw(2'd1, 8'h3C);
    unlock();
    bw(2'd2, 8'h06);
    count_busy(c);
    chk("R6 busy length", c, WRC);
    chk("R7 flag set, busy clear", ctrl_q, 8'h14);
    irq_en = 1'b1; #1;
    chk("R10 irq with enable", irq, 1'b1);
    irq_en = 1'b0; #1;
    chk("R10 irq without enable", irq, 1'b0);
    bw(2'd2, 8'h14);
    chk("R8 flag kept by writing 1", ctrl_q[4], 1'b1);
    bw(2'd2, 8'h04);
    chk("R8 flag cleared by writing 0", ctrl_q[4], 1'b0);
    bw(2'd2, 8'h14);
    chk("R8 writing 1 does not set flag", ctrl_q[4], 1'b0);
    bw(2'd2, 8'h04);
  endtask

  task automatic t_read();
    bw(2'd1, 8'h00);
    rd_byte(8'h05);
    chk("R2 read returns byte", data_q, 8'h3C);
    chk("R2 read bit reads 0", ctrl_q[0], 1'b0);
    bw(2'd1, 8'h11);
    bw(2'd2, 8'hC5);
    chk("R2 no read with memory select set", data_q, 8'h11);
    bw(2'd2, 8'h04);
  endtask

  task automatic t_hold();
    rd_byte(8'h05);
    bw(2'd0, 8'h07);
    bw(2'd2, 8'h04);
    repeat (3) @(negedge clk);
    chk("R11 data held", data_q, 8'h3C);
    bw(2'd1, 8'h99);
    chk("R11 direct data write", data_q, 8'h99);
  endtask

  task automatic t_broken();
    bw(2'd0, 8'h05);
    bw(2'd1, 8'h77);
    bw(2'd3, 8'h55); bw(2'd0, 8'h05); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    chk("R3 interrupted sequence", ctrl_q[1], 1'b0);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAB); bw(2'd2, 8'h06);
    chk("R3 wrong key value", ctrl_q[1], 1'b0);
    bw(2'd3, 8'hAA); bw(2'd3, 8'h55); bw(2'd2, 8'h06);
    chk("R3 keys out of order", ctrl_q[1], 1'b0);
    repeat (WRC + 2) @(negedge clk);
    chk("R3 no completion flag", ctrl_q[4], 1'b0);
    rd_byte(8'h05);
    chk("R3 byte unchanged", data_q, 8'h3C);
  endtask

  task automatic t_wren();
    bw(2'd2, 8'h00);
    unlock();
    bw(2'd2, 8'h06);
    chk("R5 same-write enable refused", ctrl_q, 8'h04);
    bw(2'd2, 8'hC4);
    unlock();
    bw(2'd2, 8'hC6);
    chk("R5 memory select blocks write", ctrl_q[1], 1'b0);
    bw(2'd2, 8'h04);
  endtask

  task automatic t_consume();
    int c;
    unlock();
    bw(2'd2, 8'h04);
    bw(2'd2, 8'h06);
    chk("R4 unlock used by plain control write", ctrl_q[1], 1'b0);
    bw(2'd0, 8'h06);
    bw(2'd1, 8'hA5);
    unlock();
    bw(2'd2, 8'h06);
    count_busy(c);
    bw(2'd2, 8'h06);
    chk("R4 second write needs new keys", ctrl_q[1], 1'b0);
    bw(2'd2, 8'h04);
    rd_byte(8'h06);
    chk("R7 written byte readable", data_q, 8'hA5);
  endtask

  task automatic t_busy();
    int c;
    int n;
    bw(2'd0, 8'h09);
    bw(2'd1, 8'h5A);
    unlock();
    bw(2'd2, 8'h06);
    n = 0;
    bw(2'd0, 8'h0A); n++;
    bw(2'd1, 8'hFF); n++;
    bw(2'd2, 8'h01); n++;
    chk("R9 read ignored while busy", data_q, 8'hFF);
    chk("R6 wren clear keeps write going", ctrl_q[1], 1'b1);
    bw(2'd2, 8'h04); n++;
    bw(2'd3, 8'h55); n++;
    bw(2'd3, 8'hAA); n++;
    bw(2'd2, 8'h06); n++;
    count_busy(c);
    chk("R9 no restart, total busy length", n + c, WRC);
    chk("R7 flag after busy write", ctrl_q[4], 1'b1);
    bw(2'd2, 8'h04);
    rd_byte(8'h09);
    chk("R6 latched address and data", data_q, 8'h5A);
  endtask

  task automatic t_reset_mem();
    t_reset();
    rd_byte(8'h05);
    chk("R1 memory kept through reset", data_q, 8'h3C);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_read();
    t_hold();
    t_broken();
    t_wren();
    t_consume();
    t_busy();
    t_reset_mem();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule